// File: doc/BRIEF.md
# Program Counter History Trace Buffer

This debug block keeps a rolling record of the program counter values of retired instructions in a small on-chip circular memory. While its capture enable is set, every retire pulse from the core stores the accompanying PC at the current write slot and moves the slot forward by one, wrapping at the end of the memory. A bus error from the core clears the capture enable. The trail of instructions that led to the fault therefore stays intact until software sets the enable again.

Software reaches the block through four word registers: a control register holding the capture enable, a writable read-slot register, a data register that returns the entry at the read slot, and a read-only copy of the write slot. The write slot marks the oldest entry once the buffer has wrapped. When the debug parameter is cleared, the block builds no storage and reads back as zero.

Top module: `pc_trace_buf`

## Requirements
- R1: After reset the capture enable is 0, the write slot is 0, the read slot is 0 and reg_rdata is 0.
- R2: When the capture enable is 1 and retire is high on a clock edge, retire_pc is stored at the write slot and the write slot increases by one.
- R3: The slot is 7 bits wide (128 entries). After slot 127 the write slot wraps to 0 and older entries are overwritten.
- R4: When the capture enable is 0 or retire is low, nothing is stored and the write slot keeps its value.
- R5: bus_err high on an edge clears the capture enable, even if software sets the enable in the same cycle. A retire in that same cycle is still recorded.
- R6: Writing address 1 sets the read slot to reg_wdata[6:0]; reading address 1 returns the read slot zero-extended.
- R7: A read of address 2 returns the entry at the read slot on reg_rdata in the cycle after the reg_rd strobe. Address 0 reads the capture enable in bit 0.
- R8: Address 3 reads the write slot zero-extended. Writes to addresses 2 and 3 change no state.
- R9: reg_rdata changes only in the cycle after a read strobe (or on reset) and holds its value otherwise.
- R10: With DEBUG_EN = 0, reg_rdata is always 0 and no capture takes place.
- R11: Reset does not clear the stored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire | input | 1 | One instruction retires this cycle |
| retire_pc | input | PC_W | PC of the retiring instruction |
| bus_err | input | 1 | Bus error event; stops capture |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 read slot, 2 data, 3 write slot |
| reg_wdata | input | PC_W | Register write data |
| reg_rdata | output | PC_W | Registered read data, valid the cycle after reg_rd |

## Verification
On every cycle, the assertions check that the write slot advances by one (modulo 128) exactly when a capture happens and holds otherwise. They also check that a bus error always leaves capture disabled, that the post-reset state is clean, and that read data never moves without a read strobe. Only the bench scenarios can show that the right PCs land in the right slots. The same goes for the wrap overwriting the oldest entries, bus-error priority over a simultaneous software enable, writes to read-only addresses being ignored, entries surviving a reset, and the disabled build reading zero.

// File: rtl/pc_trace_pkg.sv
package pc_trace_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_RIDX  = 2'd1,
    REG_RDATA = 2'd2,
    REG_WIDX  = 2'd3
  } trace_reg_e;
endpackage

// File: rtl/trace_ram.sv
// Simple dual-port memory, one write port and one registered read port.
module trace_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/trace_capture.sv
// Capture enable and write slot counter.
module trace_capture #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retire,
  input  logic             bus_err,
  input  logic             sw_set,
  input  logic             sw_val,
  output logic             cap_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_fire
);
  assign wr_fire = cap_en & retire;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_en <= 1'b0;
      wr_idx <= '0;
    end else begin
      if (bus_err)     cap_en <= 1'b0;
      else if (sw_set) cap_en <= sw_val;
      if (wr_fire)     wr_idx <= wr_idx + 1'b1;
    end
  end
endmodule

// File: rtl/trace_regs.sv
// Software register file and registered read path.
module trace_regs
  import pc_trace_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [PC_W-1:0]  reg_wdata,
  input  logic             cap_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  ram_q,
  output logic [IDX_W-1:0] rd_idx,
  output logic             ctrl_wr,
  output logic             ctrl_val,
  output logic             ram_re,
  output logic [PC_W-1:0]  reg_rdata
);
  trace_reg_e        sel;
  logic [PC_W-1:0]   misc_q;
  logic              use_ram_q;

  assign sel      = trace_reg_e'(reg_addr);
  assign ctrl_wr  = reg_wr && (sel == REG_CTRL);
  assign ctrl_val = reg_wdata[0];
  assign ram_re   = reg_rd && (sel == REG_RDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_idx <= '0;
    end else if (reg_wr && sel == REG_RIDX) begin
      rd_idx <= reg_wdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      misc_q    <= '0;
      use_ram_q <= 1'b0;
    end else if (reg_rd) begin
      use_ram_q <= (sel == REG_RDATA);
      case (sel)
        REG_CTRL: misc_q <= PC_W'(cap_en);
        REG_RIDX: misc_q <= PC_W'(rd_idx);
        REG_WIDX: misc_q <= PC_W'(wr_idx);
        default:  misc_q <= '0;
      endcase
    end
  end

  assign reg_rdata = use_ram_q ? ram_q : misc_q;
endmodule

// File: rtl/pc_trace_buf.sv
module pc_trace_buf #(
  parameter int PC_W     = 32,
  parameter int IDX_W    = 7,
  parameter bit DEBUG_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            retire,
  input  logic [PC_W-1:0] retire_pc,
  input  logic            bus_err,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [1:0]      reg_addr,
  input  logic [PC_W-1:0] reg_wdata,
  output logic [PC_W-1:0] reg_rdata
);
  logic             cap_en;
  logic [IDX_W-1:0] wr_idx;

  generate
    if (DEBUG_EN) begin : g_trace
      logic             wr_fire;
      logic             ctrl_wr;
      logic             ctrl_val;
      logic             ram_re;
      logic [IDX_W-1:0] rd_idx;
      logic [PC_W-1:0]  ram_q;

      trace_capture #(.IDX_W(IDX_W)) u_cap (
        .clk(clk), .rst(rst), .retire(retire), .bus_err(bus_err),
        .sw_set(ctrl_wr), .sw_val(ctrl_val),
        .cap_en(cap_en), .wr_idx(wr_idx), .wr_fire(wr_fire)
      );

      trace_ram #(.DATA_W(PC_W), .ADDR_W(IDX_W)) u_ram (
        .clk(clk), .we(wr_fire), .waddr(wr_idx), .wdata(retire_pc),
        .re(ram_re), .raddr(rd_idx), .rdata(ram_q)
      );

      trace_regs #(.PC_W(PC_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .cap_en(cap_en), .wr_idx(wr_idx), .ram_q(ram_q),
        .rd_idx(rd_idx), .ctrl_wr(ctrl_wr), .ctrl_val(ctrl_val),
        .ram_re(ram_re), .reg_rdata(reg_rdata)
      );
    end else begin : g_none
      assign cap_en    = 1'b0;
      assign wr_idx    = '0;
      assign reg_rdata = '0;
    end
  endgenerate
endmodule

// File: rtl/pc_trace_chk.sv
module pc_trace_chk #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             retire,
  input logic             bus_err,
  input logic             reg_rd,
  input logic [PC_W-1:0]  reg_rdata,
  input logic             cap_en,
  input logic [IDX_W-1:0] wr_idx
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wr_idx == '0 && !cap_en && reg_rdata == '0));

  // R2 and R3: advance by one, wrapping modulo the slot width
  assert_slot_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (cap_en && retire) |=> (wr_idx == IDX_W'($past(wr_idx) + 1'b1)));

  assert_slot_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(cap_en && retire) |=> $stable(wr_idx));

  assert_bus_err_stop_R5: assert property (@(posedge clk) disable iff (rst)
    bus_err |=> !cap_en);

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind pc_trace_buf pc_trace_chk #(.PC_W(PC_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .retire(retire), .bus_err(bus_err),
  .reg_rd(reg_rd), .reg_rdata(reg_rdata), .cap_en(cap_en), .wr_idx(wr_idx)
);

// File: tb/tb_pc_trace_buf.sv
module tb_pc_trace_buf;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W  = 32;
  localparam int DEPTH = 128;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            retire = 1'b0;
  logic [PC_W-1:0] retire_pc = '0;
  logic            bus_err = 1'b0;
  logic            reg_wr = 1'b0;
  logic            reg_rd = 1'b0;
  logic [1:0]      reg_addr = '0;
  logic [PC_W-1:0] reg_wdata = '0;
  logic [PC_W-1:0] reg_rdata;
  logic [PC_W-1:0] off_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [PC_W-1:0] model [DEPTH];
  int  m_widx = 0;
  bit  m_en   = 1'b0;

  logic [PC_W-1:0] exp_q [$];
  string           tag_q [$];
  logic            pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_trace_buf dut (
    .clk(clk), .rst(rst), .retire(retire), .retire_pc(retire_pc),
    .bus_err(bus_err), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  pc_trace_buf #(.DEBUG_EN(1'b0)) dut_off (
    .clk(clk), .rst(rst), .retire(retire), .retire_pc(retire_pc),
    .bus_err(bus_err), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(off_rdata)
  );

  task automatic check(input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard one cycle after each read strobe
  always @(posedge clk) pend <= reg_rd && !rst;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected read data actual=%h expected=none", reg_rdata);
      end else begin
        check(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic reg_read(input logic [1:0] a, input logic [PC_W-1:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [PC_W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 2'd0) m_en = d[0];
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_retire(input logic [PC_W-1:0] pc);
    retire = 1'b1; retire_pc = pc;
    if (m_en) begin model[m_widx] = pc; m_widx = (m_widx + 1) % DEPTH; end
    @(negedge clk);
    retire = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] held;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(reg_rdata, '0, "R1 rdata after reset");
    reg_read(2'd0, 32'd0, "R1 capture enable after reset");
    reg_read(2'd3, 32'd0, "R1 write slot after reset");
    reg_read(2'd1, 32'd0, "R1 read slot after reset");

    // capture disabled: retires ignored
    for (int i = 0; i < 3; i++) do_retire(32'hDEAD_0000 + i);
    reg_read(2'd3, 32'd0, "R4 no advance while disabled");

    // enable and record with gaps
    reg_write(2'd0, 32'd1);
    reg_read(2'd0, 32'd1, "R7 control reads enable");
    for (int i = 0; i < 5; i++) begin
      do_retire(32'h1000_0000 + 32'(i) * 4);
      idle(i % 2);
    end
    idle(2);
    reg_read(2'd3, 32'd5, "R2 write slot after five captures");
    reg_write(2'd0, 32'd0);
    for (int i = 0; i < 5; i++) begin
      reg_write(2'd1, 32'(i));
      reg_read(2'd2, model[i], "R2 stored pc at slot");
    end

    // read slot width
    reg_write(2'd1, 32'hFFFF_FF85);
    reg_read(2'd1, 32'h0000_0005, "R6 read slot keeps low 7 bits");

    // writes to read-only addresses
    reg_write(2'd3, 32'h55);
    reg_read(2'd3, 32'd5, "R8 write slot unchanged by write");
    reg_write(2'd2, 32'hDEAD_BEEF);
    reg_write(2'd1, 32'd0);
    reg_read(2'd2, model[0], "R8 entry unchanged by data write");

    // output holds without a read strobe
    idle(1);
    held = reg_rdata;
    reg_write(2'd1, 32'd3);
    reg_write(2'd0, 32'd1);
    do_retire(32'h2000_0000);
    reg_write(2'd0, 32'd0);
    idle(2);
    check(reg_rdata, held, "R9 rdata held without read");

    // wrap-around
    reg_write(2'd0, 32'd1);
    for (int i = 0; i < 130; i++) do_retire(32'h3000_0000 + 32'(i) * 4);
    reg_write(2'd0, 32'd0);
    reg_read(2'd3, 32'(m_widx), "R3 write slot wrapped");
    for (int i = 0; i < DEPTH; i++) begin
      reg_write(2'd1, 32'(i));
      reg_read(2'd2, model[i], "R3 entry after wrap");
    end

    // bus error beats software enable; same-cycle retire recorded
    reg_write(2'd0, 32'd1);
    do_retire(32'h4000_0000);
    do_retire(32'h4000_0004);
    bus_err = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd1;
    retire = 1'b1; retire_pc = 32'h4000_0008;
    model[m_widx] = 32'h4000_0008; m_widx = (m_widx + 1) % DEPTH; m_en = 1'b0;
    @(negedge clk);
    bus_err = 1'b0; reg_wr = 1'b0; retire = 1'b0;
    reg_read(2'd0, 32'd0, "R5 enable cleared by bus error");
    for (int i = 0; i < 3; i++) do_retire(32'h5000_0000 + i);
    reg_read(2'd3, 32'(m_widx), "R5 capture frozen after bus error");
    reg_write(2'd1, 32'((m_widx + DEPTH - 1) % DEPTH));
    reg_read(2'd2, 32'h4000_0008, "R5 retire in bus error cycle recorded");

    // reset keeps the buffer
    rst = 1'b1; idle(2); rst = 1'b0;
    @(negedge clk);
    reg_read(2'd3, 32'd0, "R1 write slot cleared by reset");
    for (int i = 0; i < 4; i++) begin
      reg_write(2'd1, 32'(i * 37));
      reg_read(2'd2, model[i * 37], "R11 entry survives reset");
    end

    // disabled build
    check(off_rdata, '0, "R10 disabled build reads zero");
    idle(2);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R7 missing read data actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // disabled build must stay zero while the enabled one is read
  always @(negedge clk) begin
    if (!rst && pend && off_rdata !== '0) begin
      checks++; errors++;
      $display("FAIL R10 disabled build actual=%h expected=0", off_rdata);
    end
  end
endmodule